// File: doc/BRIEF.md
# Power-Up Reset Timeout Sequencer

This block keeps the processor core in reset after a power-on, a brown-out or a wake-up from sleep, until the start-up delays required by the selected oscillator have run out. It has two delay stages. The first is a long power-up timer that counts on a reference timer clock. The second is an oscillator start-up timer that counts oscillator periods and is used only for crystal-type oscillators. Which stages run depends on the oscillator selection and on a bit that disables the power-up timer. A wake-up from sleep runs a shorter delay that also depends on the oscillator.

The external active-low reset pin is synchronized and combined with the sequencer at the output. It does not gate the delays. A board that holds the pin low for longer than the delays therefore sees the core start a fixed, short time after the pin rises. This makes it possible to start several devices together. The internal reset output comes straight from a register. It asserts at once when a power event arrives and deasserts synchronously to the reference clock. A separate flag reports that the power-up delays have finished, and it stays set until the next power event.

Top module: `por_timeout_seq`

## Requirements
- R1: While `por_evt` or `bor_evt` is high, `core_rst_n` and `tmo_done` are 0, without waiting for a clock edge.
- R2: With `osc_sel` = 01 (RC or external clock) or 10 (internal oscillator) and `ext_rst_n` high, `core_rst_n` rises exactly 3 + PWRT_CYCLES rising edges of `clk_ref` after the power event falls when `pwrt_off` = 0, and exactly 3 edges after it falls when `pwrt_off` = 1. The 3 edges are two for the reset synchronizer and one for sequencing.
- R3: With `osc_sel` = 00 or 11 (crystal) and `pwrt_off` = 0, the power-up timer runs first and then OST_CYCLES periods of `clk_osc`. Release comes no earlier than 3 + PWRT_CYCLES reference cycles plus OST_CYCLES oscillator periods, and no later than that plus a bounded clock-crossing handshake of a few cycles.
- R4: With a crystal selection and `pwrt_off` = 1, only the OST_CYCLES oscillator delay runs after the 3-edge synchronizer and sequencing latency.
- R5: A pulse on `bor_evt` follows exactly the same delay rules as a pulse on `por_evt`, for every oscillator selection and every `pwrt_off` value.
- R6: A new power event during any delay stage restarts the whole sequence. The full delay is measured again from the falling edge of the latest event.
- R7: The delays run regardless of `ext_rst_n`. If the pin is low when the delays finish, `core_rst_n` stays 0 and rises exactly 3 `clk_ref` edges after the pin rises. A pin falling while the core is running drives `core_rst_n` low exactly 3 edges later.
- R8: `tmo_done` rises on the same edge on which the last active power-up stage completes. This is 3 + PWRT_CYCLES edges in RC mode, whatever the pin does. It then stays 1 through pin activity and sleep wake-ups until the next power event.
- R9: A `wake_evt` pulse in the run state with a crystal selection holds `core_rst_n` low for OST_CYCLES oscillator periods plus the handshake overhead.
- R10: A `wake_evt` pulse in the run state with `osc_sel` = 10 holds `core_rst_n` low for exactly WAKE_CYCLES `clk_ref` cycles, starting at the edge that samples the pulse.
- R11: A `wake_evt` pulse with `osc_sel` = 01 has no effect: `core_rst_n` stays 1.
- R12: A `wake_evt` pulse that arrives while a power-up delay is still running is ignored, and the release time does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference timer clock; sequencer and long delays |
| clk_osc | input | 1 | Oscillator clock; start-up period counter |
| por_evt | input | 1 | Power-on pulse, active high, asynchronous |
| bor_evt | input | 1 | Brown-out detect, active high, asynchronous |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| osc_sel | input | 2 | 00/11 crystal, 01 RC or external clock, 10 internal oscillator |
| pwrt_off | input | 1 | 1 disables the power-up timer stage |
| wake_evt | input | 1 | One-cycle sleep wake-up pulse, synchronous to clk_ref |
| core_rst_n | output | 1 | Internal core reset, active low, registered |
| tmo_done | output | 1 | Power-up delays have expired |

## Verification
The bench builds the block with PWRT_CYCLES = 40, OST_CYCLES = 16, WAKE_CYCLES = 6 and two synchronizer stages, which shrinks the 72 ms and 1024-period delays to a few dozen cycles. That makes it possible to sweep every oscillator selection against both `pwrt_off` values and both event sources, and to compare each release against a cycle count worked out by arithmetic. The oscillator runs at 2/3 of the reference rate, so the start-up stage actually crosses clock domains and its result is checked against a window. The short delays also leave room to restart the sequence part-way, to hold the pin low past the delays, and to run every wake-up variant in one run.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

   // Oscillator selection codes; 11 is treated as a crystal family
   typedef enum logic [1:0] {
      OSEL_XTAL     = 2'b00,
      OSEL_RC       = 2'b01,
      OSEL_INTOSC   = 2'b10,
      OSEL_XTAL_ALT = 2'b11
   } osc_sel_e;

   typedef enum logic [2:0] {
      ST_SETTLE   = 3'd0,
      ST_PWRT     = 3'd1,
      ST_OST      = 3'd2,
      ST_RUN      = 3'd3,
      ST_WAKE_OST = 3'd4,
      ST_WAKE_INT = 3'd5
   } seq_state_e;

   function automatic logic needs_ost(input logic [1:0] sel);
      return (sel == OSEL_XTAL) || (sel == OSEL_XTAL_ALT);
   endfunction

endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
   parameter int STAGES  = 2,
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic arst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pwrseq_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain_q <= {STAGES{RST_VAL}};
      else         chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/pwrseq_ost.sv
module pwrseq_ost #(
   parameter int OST_CYCLES  = 1024,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_osc,
   input  logic arst_n,
   input  logic req_i,
   output logic done_o
);

   localparam int CW = (OST_CYCLES > 1) ? $clog2(OST_CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(OST_CYCLES - 1);

   generate
      if (OST_CYCLES < 2) begin : g_bad_ost
         $error("pwrseq_ost: OST_CYCLES must be at least 2");
      end
   endgenerate

   logic          req_s;
   logic [CW-1:0] cnt_q;

   pwrseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_req_sync (
      .clk    (clk_osc),
      .arst_n (arst_n),
      .d      (req_i),
      .q      (req_s)
   );

   always_ff @(posedge clk_osc or negedge arst_n) begin
      if (!arst_n) begin
         cnt_q  <= '0;
         done_o <= 1'b0;
      end else if (!req_s) begin
         cnt_q  <= '0;
         done_o <= 1'b0;
      end else if (!done_o) begin
         if (cnt_q == LAST) done_o <= 1'b1;
         else               cnt_q  <= cnt_q + CW'(1);
      end
   end

   // R3
   ost_done_needs_req_chk: assert property (@(posedge clk_osc) disable iff (!arst_n)
      $rose(done_o) |-> req_s);

   // R9
   ost_done_drops_chk: assert property (@(posedge clk_osc) disable iff (!arst_n)
      (done_o && !req_s) |=> !done_o);

endmodule

// File: rtl/por_timeout_seq.sv
module por_timeout_seq #(
   parameter int PWRT_CYCLES = 72000,
   parameter int OST_CYCLES  = 1024,
   parameter int WAKE_CYCLES = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk_ref,
   input  logic       clk_osc,
   input  logic       por_evt,
   input  logic       bor_evt,
   input  logic       ext_rst_n,
   input  logic [1:0] osc_sel,
   input  logic       pwrt_off,
   input  logic       wake_evt,
   output logic       core_rst_n,
   output logic       tmo_done
);
   import pwrseq_pkg::*;

   localparam int TMAX = (PWRT_CYCLES > WAKE_CYCLES) ? PWRT_CYCLES : WAKE_CYCLES;
   localparam int TW   = $clog2(TMAX + 1);
   localparam logic [TW-1:0] PWRT_LOAD = TW'(PWRT_CYCLES - 1);
   localparam logic [TW-1:0] WAKE_LOAD = TW'(WAKE_CYCLES - 1);

   generate
      if (PWRT_CYCLES < 1) begin : g_bad_pwrt
         $error("por_timeout_seq: PWRT_CYCLES must be at least 1");
      end
      if (WAKE_CYCLES < 1) begin : g_bad_wake
         $error("por_timeout_seq: WAKE_CYCLES must be at least 1");
      end
   endgenerate

   logic pwr_evt_n;
   logic ref_rst_n;
   logic osc_rst_n;
   logic pin_s;
   logic ost_done_s;
   logic ost_done_osc;

   assign pwr_evt_n = ~(por_evt | bor_evt);

   // reset synchronizers: assert at once, release after SYNC_STAGES edges
   pwrseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ref_rst (
      .clk (clk_ref), .arst_n (pwr_evt_n), .d (1'b1), .q (ref_rst_n)
   );
   pwrseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_osc_rst (
      .clk (clk_osc), .arst_n (pwr_evt_n), .d (1'b1), .q (osc_rst_n)
   );

   // external pin, not reset by power events
   pwrseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pin_sync (
      .clk (clk_ref), .arst_n (1'b1), .d (ext_rst_n), .q (pin_s)
   );

   seq_state_e    state_q, state_d;
   logic [TW-1:0] cnt_q, cnt_d;
   logic          req_q, req_d;
   logic          rst_q, done_q;

   pwrseq_ost #(.OST_CYCLES(OST_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_ost (
      .clk_osc (clk_osc),
      .arst_n  (osc_rst_n),
      .req_i   (req_q),
      .done_o  (ost_done_osc)
   );

   pwrseq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_done_sync (
      .clk (clk_ref), .arst_n (ref_rst_n), .d (ost_done_osc), .q (ost_done_s)
   );

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      req_d   = req_q;
      unique case (state_q)
         ST_SETTLE: begin
            if (!pwrt_off) begin
               state_d = ST_PWRT;
               cnt_d   = PWRT_LOAD;
            end else if (needs_ost(osc_sel)) begin
               state_d = ST_OST;
            end else begin
               state_d = ST_RUN;
            end
         end
         ST_PWRT: begin
            if (cnt_q == '0) state_d = needs_ost(osc_sel) ? ST_OST : ST_RUN;
            else             cnt_d   = cnt_q - TW'(1);
         end
         ST_OST, ST_WAKE_OST: begin
            // four-phase request towards the oscillator domain
            if (!req_q && !ost_done_s) begin
               req_d = 1'b1;
            end else if (req_q && ost_done_s) begin
               req_d   = 1'b0;
               state_d = ST_RUN;
            end
         end
         ST_RUN: begin
            if (wake_evt) begin
               if (needs_ost(osc_sel)) begin
                  state_d = ST_WAKE_OST;
               end else if (osc_sel == OSEL_INTOSC) begin
                  state_d = ST_WAKE_INT;
                  cnt_d   = WAKE_LOAD;
               end
            end
         end
         ST_WAKE_INT: begin
            if (cnt_q == '0) state_d = ST_RUN;
            else             cnt_d   = cnt_q - TW'(1);
         end
         default: state_d = ST_SETTLE;
      endcase
   end

   always_ff @(posedge clk_ref or negedge ref_rst_n) begin
      if (!ref_rst_n) begin
         state_q <= ST_SETTLE;
         cnt_q   <= '0;
         req_q   <= 1'b0;
         rst_q   <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
         req_q   <= req_d;
         rst_q   <= (state_d == ST_RUN) && pin_s;
         done_q  <= done_q | (state_d == ST_RUN);
      end
   end

   assign core_rst_n = rst_q;
   assign tmo_done   = done_q;

   // R2
   release_after_done_chk: assert property (@(posedge clk_ref) disable iff (!ref_rst_n)
      core_rst_n |-> tmo_done);

   // R7
   pin_forces_reset_chk: assert property (@(posedge clk_ref) disable iff (!ref_rst_n)
      !pin_s |=> !core_rst_n);

   // R8
   done_sticky_chk: assert property (@(posedge clk_ref) disable iff (!ref_rst_n)
      tmo_done |=> tmo_done);

   // R2
   pwrt_counts_down_chk: assert property (@(posedge clk_ref) disable iff (!ref_rst_n)
      (state_q == ST_PWRT && cnt_q != '0) |=> (state_q == ST_PWRT && cnt_q == $past(cnt_q) - TW'(1)));

   // R11
   rc_wake_ignored_chk: assert property (@(posedge clk_ref) disable iff (!ref_rst_n)
      (state_q == ST_RUN && wake_evt && osc_sel == OSEL_RC) |=> (state_q == ST_RUN));

   // R12
   wake_outside_run_chk: assert property (@(posedge clk_ref) disable iff (!ref_rst_n)
      (state_q == ST_PWRT && wake_evt) |=> (state_q != ST_WAKE_INT && state_q != ST_WAKE_OST));

endmodule

// File: tb/por_timeout_seq_tb_top.sv
module por_timeout_seq_tb_top;

   localparam int P   = 40;
   localparam int OST = 16;
   localparam int W   = 6;
   // oscillator period 30 ns against 20 ns reference: OST periods in ref cycles
   localparam int OST_REF = (OST * 30 + 19) / 20;
   localparam int SLACK   = 16;

   logic clk_ref = 1'b0;
   logic clk_osc = 1'b0;
   logic por_evt = 1'b1;
   logic bor_evt = 1'b0;
   logic ext_rst_n = 1'b1;
   logic [1:0] osc_sel = 2'b01;
   logic pwrt_off = 1'b0;
   logic wake_evt = 1'b0;
   logic core_rst_n;
   logic tmo_done;

   int checks = 0;
   int errors = 0;

   always #10 clk_ref = ~clk_ref;
   always #15 clk_osc = ~clk_osc;

   por_timeout_seq #(
      .PWRT_CYCLES (P),
      .OST_CYCLES  (OST),
      .WAKE_CYCLES (W),
      .SYNC_STAGES (2)
   ) dut_i (
      .clk_ref    (clk_ref),
      .clk_osc    (clk_osc),
      .por_evt    (por_evt),
      .bor_evt    (bor_evt),
      .ext_rst_n  (ext_rst_n),
      .osc_sel    (osc_sel),
      .pwrt_off   (pwrt_off),
      .wake_evt   (wake_evt),
      .core_rst_n (core_rst_n),
      .tmo_done   (tmo_done)
   );

   task automatic check_range(input string tag, input int act, input int lo, input int hi);
      checks++;
      if (act < lo || act > hi) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d..%0d", tag, act, lo, hi);
      end
   endtask

   task automatic check_eq(input string tag, input int act, input int exp);
      check_range(tag, act, exp, exp);
   endtask

   // raise one event source, check outputs, release at a falling edge
   task automatic pulse_event(input bit use_bor);
      @(negedge clk_ref);
      if (use_bor) bor_evt = 1'b1; else por_evt = 1'b1;
      #3;
      check_eq("R1 core_rst_n during event", int'(core_rst_n), 0);
      check_eq("R1 tmo_done during event", int'(tmo_done), 0);
      repeat (4) @(negedge clk_ref);
      por_evt = 1'b0;
      bor_evt = 1'b0;
   endtask

   // count rising edges until core_rst_n is seen high; wake pulse at edge wake_at
   task automatic measure_release(input int wake_at, output int n);
      n = 0;
      while (n < 400) begin
         wake_evt = (n + 1 == wake_at);
         @(posedge clk_ref);
         n++;
         @(negedge clk_ref);
         wake_evt = 1'b0;
         if (core_rst_n) break;
      end
   endtask

   task automatic count_wake_low(output int n);
      @(negedge clk_ref);
      wake_evt = 1'b1;
      @(negedge clk_ref);
      wake_evt = 1'b0;
      n = 0;
      while (!core_rst_n && n < 200) begin
         n++;
         @(negedge clk_ref);
      end
   endtask

   function automatic int exp_lo(input logic [1:0] sel, input bit off);
      int v = 3;
      if (!off) v += P;
      if (sel == 2'b00 || sel == 2'b11) v += OST_REF;
      return v;
   endfunction

   function automatic int exp_hi(input logic [1:0] sel, input bit off);
      if (sel == 2'b00 || sel == 2'b11) return exp_lo(sel, off) + SLACK;
      return exp_lo(sel, off);
   endfunction

   initial begin : watchdog
      #(200000 * 20);
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      int n;
      repeat (3) @(negedge clk_ref);
      check_eq("R1 reset state core_rst_n", int'(core_rst_n), 0);
      check_eq("R1 reset state tmo_done", int'(tmo_done), 0);
      por_evt = 1'b0;
      measure_release(0, n);

      // R2 R3 R4 R5: sweep of selection, timer disable and event source
      for (int src = 0; src < 2; src++) begin
         for (int s = 0; s < 4; s++) begin
            for (int off = 0; off < 2; off++) begin
               osc_sel  = 2'(s);
               pwrt_off = off[0];
               pulse_event(src[0]);
               measure_release(0, n);
               check_range($sformatf("R2/R3/R4/R5 release sel=%0d off=%0d bor=%0d", s, off, src),
                           n, exp_lo(2'(s), off[0]), exp_hi(2'(s), off[0]));
            end
         end
      end

      // R6: brown-out part-way through the power-up timer restarts it
      osc_sel = 2'b01; pwrt_off = 1'b0;
      pulse_event(1'b0);
      repeat (20) @(negedge clk_ref);
      pulse_event(1'b1);
      measure_release(0, n);
      check_eq("R6 restart during timer", n, 3 + P);

      // R6: power-on part-way through the crystal start-up stage
      osc_sel = 2'b00;
      pulse_event(1'b1);
      repeat (P + 10) @(negedge clk_ref);
      pulse_event(1'b0);
      measure_release(0, n);
      check_range("R6 restart during start-up stage", n, exp_lo(2'b00, 1'b0), exp_hi(2'b00, 1'b0));

      // R12: wake pulse during the power-up timer is ignored
      osc_sel = 2'b10;
      pulse_event(1'b0);
      measure_release(10, n);
      check_eq("R12 wake during timer", n, 3 + P);

      // R7 R8: pin held low past the delays
      osc_sel = 2'b01;
      ext_rst_n = 1'b0;
      pulse_event(1'b0);
      n = 0;
      while (!tmo_done && n < 400) begin
         @(posedge clk_ref); n++; @(negedge clk_ref);
      end
      check_eq("R8 done edge with pin low", n, 3 + P);
      repeat (10) @(negedge clk_ref);
      check_eq("R7 reset held by pin", int'(core_rst_n), 0);
      ext_rst_n = 1'b1;
      n = 0;
      while (!core_rst_n && n < 50) begin
         @(posedge clk_ref); n++; @(negedge clk_ref);
      end
      check_eq("R7 release after pin rise", n, 3);
      ext_rst_n = 1'b0;
      n = 0;
      while (core_rst_n && n < 50) begin
         @(posedge clk_ref); n++; @(negedge clk_ref);
      end
      check_eq("R7 assert after pin fall", n, 3);
      check_eq("R8 done kept through pin", int'(tmo_done), 1);
      ext_rst_n = 1'b1;
      repeat (5) @(negedge clk_ref);

      // R10: internal oscillator wake
      osc_sel = 2'b10;
      count_wake_low(n);
      check_eq("R10 intosc wake low cycles", n, W);

      // R11: RC wake has no effect
      osc_sel = 2'b01;
      count_wake_low(n);
      check_eq("R11 RC wake low cycles", n, 0);
      repeat (5) @(negedge clk_ref);
      check_eq("R11 RC wake reset stays high", int'(core_rst_n), 1);

      // R9: crystal wake
      osc_sel = 2'b11;
      count_wake_low(n);
      check_range("R9 crystal wake low cycles", n, OST_REF, OST_REF + SLACK);
      check_eq("R8 done kept through wake", int'(tmo_done), 1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule